// File: doc/BRIEF.md
# Outstanding Line Transaction Table

This block keeps a small, fully associative table of line addresses that have work in flight below a cache controller. Each busy slot records a transient state, a bit-vector of the requestors waiting on the line, a dirty flag and a count of atomic operations still outstanding. The controller presents one request per cycle. The table merges the request into a matching slot or claims a free slot, and tells the controller whether the request must travel downstream. If the request cannot be taken, the table holds it off.

Responses from below arrive on a separate port and are matched by line address. A fill returns a vector of every waiting requestor, so the controller can fan the data out to all of them, and raises an unblock pulse. After a fill the slot is released. An atomic data response lowers the slot's atomic count. When the count reaches zero, the slot queues a completion trigger to itself and presents it one cycle later. If the count is still zero when that trigger is handled, the slot is released. A write acknowledge releases a write slot. A separate lookup port shows any slot's contents within the same cycle.

Top module: `mt_table`

## Requirements
- R1: A slot claimed by a new line starts with an atomic count of zero. Its waiting set holds only the requestor of the claiming request, and is empty for a write.
- R2: Read requests (req_kind 0) and atomic requests (req_kind 2) add their requestor bit (bit req_src) to the waiting set. Write requests (req_kind 1) add no requestor, set the slot's dirty flag and open the slot in write state (lk_state 3).
- R3: An accepted read raises fwd_valid only when the waiting set, after the read is merged, holds exactly one requestor. Later reads to the same line are merged without a forward. Every accepted write or atomic raises fwd_valid.
- R4: A fill response (rsp_kind 0) that hits a line in fetch state (lk_state 1) drives rsp_dest with that slot's waiting set and raises unblock in the same cycle. The slot is free from the next cycle.
- R5: Each accepted atomic request adds one to its slot's count. Each atomic data response (rsp_kind 1) that hits a slot in atomic state (lk_state 2) with a nonzero count subtracts one.
- R6: A decrement that brings the count to zero raises done_valid, with done_idx set to the slot, in the following cycle. While the trigger is shown, the slot is released if its count is zero and no atomic joins it in that cycle. Otherwise the trigger is discarded and the slot stays.
- R7: A write acknowledge (rsp_kind 2) that hits a slot in write state releases the slot. A released slot, when it is claimed again, shows no earlier requestor.
- R8: When every slot is busy, full is 1. A request that matches no slot is then refused (req_ready 0) and leaves the table unchanged.
- R9: The lookup port compares lk_addr with every busy slot. It returns hit, slot index, state (1 fetch, 2 atomic, 3 write), waiting set, count and dirty flag in the same cycle.
- R10: An atomic data response that hits a slot whose count is zero raises underflow_err in that cycle and leaves the count at zero.
- R11: A request that hits a busy line of another kind is refused (req_ready 0). This covers a write to any busy line, a read to an atomic line and an atomic to a fetch line.
- R12: After reset no slot is busy: lk_hit, full, done_valid and underflow_err are 0, and a read is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read, 1 write, 2 atomic |
| req_addr | input | ADDR_W | Request line address |
| req_src | input | $clog2(NUM_SRC) | Requestor number |
| req_ready | output | 1 | Request can be taken this cycle |
| fwd_valid | output | 1 | Accepted request must go downstream |
| fwd_kind | output | 2 | Kind of the forwarded request |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | 0 fill, 1 atomic data, 2 write acknowledge |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_dest | output | NUM_SRC | Requestors that receive the fill |
| unblock | output | 1 | Fill consumed, unblock downstream |
| done_valid | output | 1 | Atomic completion trigger |
| done_idx | output | $clog2(NUM_ENTRIES) | Slot of the trigger |
| underflow_err | output | 1 | Atomic response against a zero count |
| full | output | 1 | All slots busy |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup matched a busy slot |
| lk_idx | output | $clog2(NUM_ENTRIES) | Matching slot |
| lk_state | output | 2 | Slot state, 0 when no match |
| lk_waiters | output | NUM_SRC | Slot waiting set |
| lk_count | output | CNT_W | Slot atomic count |
| lk_dirty | output | 1 | Slot dirty flag |
| full_unused_guard | output | 1 | Reserved, driven 0 |

## Verification
The checks assume that the controller never sends a request and a response for the same line in one cycle. They also assume that a requestor does not ask for a line it is already waiting on, and that no more atomics pile onto a line than the count width can hold. The stimulus keeps to these rules: every response and every request goes to a different cycle. Each requestor appears in a line's waiting set once, and at most two atomics are in flight. Fill and write-acknowledge responses are sent only to lines opened by the matching request kind, so a release always follows a real request.

// File: rtl/mt_pkg.sv
package mt_pkg;
   // request kinds
   localparam logic [1:0] RQ_READ   = 2'd0;
   localparam logic [1:0] RQ_WRITE  = 2'd1;
   localparam logic [1:0] RQ_ATOMIC = 2'd2;
   // response kinds
   localparam logic [1:0] RS_FILL   = 2'd0;
   localparam logic [1:0] RS_ATOMIC = 2'd1;
   localparam logic [1:0] RS_WACK   = 2'd2;
   // slot states
   localparam logic [1:0] LS_IDLE   = 2'd0;
   localparam logic [1:0] LS_FETCH  = 2'd1;
   localparam logic [1:0] LS_ATOMIC = 2'd2;
   localparam logic [1:0] LS_WRITE  = 2'd3;
endpackage

// File: rtl/mt_match.sv
module mt_match #(
   parameter int N  = 4,
   parameter int AW = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    busy,
   input  logic [N*AW-1:0] tags,
   input  logic [AW-1:0]   key,
   output logic            hit,
   output logic [IW-1:0]   idx
);
   logic [N-1:0] eq;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign eq[g] = busy[g] && (tags[g*AW +: AW] == key);
   end

   assign hit = |eq;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (eq[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/mt_first_free.sv
module mt_first_free #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  busy,
   output logic          any_free,
   output logic [IW-1:0] idx
);
   assign any_free = ~&busy;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/mt_entry.sv
module mt_entry
   import mt_pkg::*;
#(
   parameter int AW = 16,
   parameter int NS = 8,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          claim,
   input  logic [AW-1:0] claim_addr,
   input  logic [1:0]    claim_state,
   input  logic [NS-1:0] add_mask,
   input  logic          mark_dirty,
   input  logic          inc,
   input  logic          dec,
   input  logic          release_now,
   output logic          busy,
   output logic [AW-1:0] tag,
   output logic [1:0]    state,
   output logic [NS-1:0] waiters,
   output logic [CW-1:0] count,
   output logic          dirty,
   output logic          trig
);
   logic free_by_trig;
   logic drop;

   assign free_by_trig = trig && (count == '0) && !inc;
   assign drop         = release_now || free_by_trig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         tag     <= '0;
         state   <= LS_IDLE;
         waiters <= '0;
         count   <= '0;
         dirty   <= 1'b0;
         trig    <= 1'b0;
      end else begin
         trig <= dec && (count == CW'(1)) && !inc;
         if (drop) begin
            busy    <= 1'b0;
            state   <= LS_IDLE;
            waiters <= '0;
            count   <= '0;
            dirty   <= 1'b0;
         end else if (claim) begin
            busy    <= 1'b1;
            tag     <= claim_addr;
            state   <= claim_state;
            waiters <= add_mask;
            count   <= inc ? CW'(1) : '0;
            dirty   <= mark_dirty;
         end else if (busy) begin
            waiters <= waiters | add_mask;
            count   <= count + CW'(inc) - CW'(dec);
            dirty   <= dirty | mark_dirty;
         end
      end
   end
endmodule

// File: rtl/mt_table.sv
module mt_table
   import mt_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int NUM_SRC     = 8,
   parameter int ADDR_W      = 16,
   parameter int CNT_W       = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [1:0]                     req_kind,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic [$clog2(NUM_SRC)-1:0]     req_src,
   output logic                           req_ready,
   output logic                           fwd_valid,
   output logic [1:0]                     fwd_kind,
   input  logic                           rsp_valid,
   input  logic [1:0]                     rsp_kind,
   input  logic [ADDR_W-1:0]              rsp_addr,
   output logic [NUM_SRC-1:0]             rsp_dest,
   output logic                           unblock,
   output logic                           done_valid,
   output logic [$clog2(NUM_ENTRIES)-1:0] done_idx,
   output logic                           underflow_err,
   output logic                           full,
   input  logic [ADDR_W-1:0]              lk_addr,
   output logic                           lk_hit,
   output logic [$clog2(NUM_ENTRIES)-1:0] lk_idx,
   output logic [1:0]                     lk_state,
   output logic [NUM_SRC-1:0]             lk_waiters,
   output logic [CNT_W-1:0]               lk_count,
   output logic                           lk_dirty,
   output logic                           full_unused_guard
);
   localparam int IW = $clog2(NUM_ENTRIES);
   localparam int SW = $clog2(NUM_SRC);

   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("mt_table: NUM_ENTRIES must be at least 2");
   end
   if (NUM_SRC < 2) begin : g_bad_src
      $error("mt_table: NUM_SRC must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("mt_table: CNT_W must be at least 1");
   end

   logic [NUM_ENTRIES-1:0]        busy_vec;
   logic [NUM_ENTRIES*ADDR_W-1:0] tag_flat;
   logic [1:0]                    e_state   [NUM_ENTRIES];
   logic [NUM_SRC-1:0]            e_waiters [NUM_ENTRIES];
   logic [CNT_W-1:0]              e_count   [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0]        e_dirty;
   logic [NUM_ENTRIES-1:0]        trig_vec;

   logic          req_hit, rsp_hit;
   logic [IW-1:0] rq_idx, rs_idx, free_idx;
   logic          any_free;

   mt_match #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_req_match (
      .busy(busy_vec), .tags(tag_flat), .key(req_addr), .hit(req_hit), .idx(rq_idx));
   mt_match #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_rsp_match (
      .busy(busy_vec), .tags(tag_flat), .key(rsp_addr), .hit(rsp_hit), .idx(rs_idx));
   mt_match #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_lk_match (
      .busy(busy_vec), .tags(tag_flat), .key(lk_addr), .hit(lk_hit), .idx(lk_idx));
   mt_first_free #(.N(NUM_ENTRIES)) u_free (
      .busy(busy_vec), .any_free(any_free), .idx(free_idx));

   // request side
   logic               is_read, is_write, is_atomic, merge_ok, accept;
   logic [NUM_SRC-1:0] src_mask, merged_set;
   logic [1:0]         open_state;

   assign is_read   = (req_kind == RQ_READ);
   assign is_write  = (req_kind == RQ_WRITE);
   assign is_atomic = (req_kind == RQ_ATOMIC);
   assign merge_ok  = (is_read && e_state[rq_idx] == LS_FETCH) ||
                      (is_atomic && e_state[rq_idx] == LS_ATOMIC);
   assign req_ready = req_hit ? merge_ok : any_free;
   assign accept    = req_valid && req_ready;
   assign src_mask  = (is_read || is_atomic) ? (NUM_SRC'(1) << req_src) : '0;
   assign merged_set = (req_hit ? e_waiters[rq_idx] : '0) | src_mask;
   assign fwd_valid = accept && (is_write || is_atomic ||
                                 (is_read && $countones(merged_set) == 1));
   assign fwd_kind  = req_kind;

   always_comb begin
      case (req_kind)
         RQ_WRITE:  open_state = LS_WRITE;
         RQ_ATOMIC: open_state = LS_ATOMIC;
         default:   open_state = LS_FETCH;
      endcase
   end

   // response side
   logic fill_hit, atom_hit;
   assign fill_hit = rsp_valid && rsp_hit && rsp_kind == RS_FILL &&
                     e_state[rs_idx] == LS_FETCH;
   assign atom_hit = rsp_valid && rsp_hit && rsp_kind == RS_ATOMIC;
   assign rsp_dest = fill_hit ? e_waiters[rs_idx] : '0;
   assign unblock  = fill_hit;
   assign underflow_err = atom_hit && (e_count[rs_idx] == '0);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      logic               sel_new, sel_old, sel_any, rsp_sel;
      logic               dec_ok, rel;
      logic [NUM_SRC-1:0] mask_g;
      logic [ADDR_W-1:0]  tag_g;

      assign sel_new = accept && !req_hit && (free_idx == IW'(g));
      assign sel_old = accept && req_hit && (rq_idx == IW'(g));
      assign sel_any = sel_new || sel_old;
      assign mask_g  = sel_any ? src_mask : '0;
      assign rsp_sel = rsp_valid && rsp_hit && (rs_idx == IW'(g));
      assign dec_ok  = rsp_sel && rsp_kind == RS_ATOMIC &&
                       e_state[g] == LS_ATOMIC && e_count[g] != '0;
      assign rel     = rsp_sel &&
                       ((rsp_kind == RS_FILL && e_state[g] == LS_FETCH) ||
                        (rsp_kind == RS_WACK && e_state[g] == LS_WRITE));

      mt_entry #(.AW(ADDR_W), .NS(NUM_SRC), .CW(CNT_W)) u_entry (
         .clk(clk), .rst_n(rst_n),
         .claim(sel_new), .claim_addr(req_addr), .claim_state(open_state),
         .add_mask(mask_g), .mark_dirty(sel_any && is_write),
         .inc(sel_any && is_atomic), .dec(dec_ok), .release_now(rel),
         .busy(busy_vec[g]), .tag(tag_g), .state(e_state[g]),
         .waiters(e_waiters[g]), .count(e_count[g]), .dirty(e_dirty[g]),
         .trig(trig_vec[g]));

      assign tag_flat[g*ADDR_W +: ADDR_W] = tag_g;
   end

   assign done_valid = |trig_vec;
   always_comb begin
      done_idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (trig_vec[i]) done_idx = IW'(i);
      end
   end

   assign full       = &busy_vec;
   assign lk_state   = lk_hit ? e_state[lk_idx] : LS_IDLE;
   assign lk_waiters = lk_hit ? e_waiters[lk_idx] : '0;
   assign lk_count   = lk_hit ? e_count[lk_idx] : '0;
   assign lk_dirty   = lk_hit && e_dirty[lk_idx];
   assign full_unused_guard = 1'b0;

   logic unused_sw;
   assign unused_sw = ^SW;
endmodule

// File: rtl/mt_table_chk.sv
module mt_table_chk #(
   parameter int NUM_ENTRIES = 4,
   parameter int NUM_SRC     = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_ready,
   input logic                   req_hit,
   input logic                   fwd_valid,
   input logic                   rsp_valid,
   input logic [1:0]             rsp_kind,
   input logic [NUM_SRC-1:0]     rsp_dest,
   input logic                   unblock,
   input logic                   done_valid,
   input logic                   underflow_err,
   input logic                   full,
   input logic [NUM_ENTRIES-1:0] trig_vec
);
   // R3: a forward only ever accompanies an accepted request
   p_fwd_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (req_valid && req_ready));

   // R4: a fill that unblocks always has someone to deliver to
   p_fill_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      unblock |-> (rsp_dest != '0));

   // R6: a trigger is preceded by an atomic data response
   p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(rsp_valid && rsp_kind == 2'd1));

   // R6: at most one slot triggers at a time
   p_trig_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trig_vec));

   // R8: a full table refuses a new line
   p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && full && !req_hit) |-> !req_ready);

   // R10: an underflow never produces a completion
   p_err_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_err |=> !done_valid);
endmodule

bind mt_table mt_table_chk #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_SRC(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_hit(req_hit), .fwd_valid(fwd_valid), .rsp_valid(rsp_valid),
   .rsp_kind(rsp_kind), .rsp_dest(rsp_dest), .unblock(unblock),
   .done_valid(done_valid), .underflow_err(underflow_err), .full(full),
   .trig_vec(trig_vec));

// File: tb/test_mt_table.sv
module test_mt_table;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [15:0] req_addr = '0;
   logic [2:0]  req_src = '0;
   logic        req_ready, fwd_valid;
   logic [1:0]  fwd_kind;
   logic        rsp_valid = 1'b0;
   logic [1:0]  rsp_kind = 2'd0;
   logic [15:0] rsp_addr = '0;
   logic [7:0]  rsp_dest;
   logic        unblock, done_valid, underflow_err, full;
   logic [1:0]  done_idx;
   logic [15:0] lk_addr = '0;
   logic        lk_hit, lk_dirty, guard;
   logic [1:0]  lk_idx, lk_state;
   logic [7:0]  lk_waiters;
   logic [3:0]  lk_count;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   mt_table i_mt_table (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_src(req_src), .req_ready(req_ready),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .rsp_valid(rsp_valid),
      .rsp_kind(rsp_kind), .rsp_addr(rsp_addr), .rsp_dest(rsp_dest),
      .unblock(unblock), .done_valid(done_valid), .done_idx(done_idx),
      .underflow_err(underflow_err), .full(full), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_state(lk_state),
      .lk_waiters(lk_waiters), .lk_count(lk_count), .lk_dirty(lk_dirty),
      .full_unused_guard(guard));

   // {kind[1:0], addr[7:0], src[2:0], exp_ready, exp_fwd}
   localparam logic [14:0] VEC [11] = '{
      {2'd0, 8'hA0, 3'd0, 1'b1, 1'b1},   // R3 first read forwarded
      {2'd0, 8'hA0, 3'd1, 1'b1, 1'b0},   // R3 merged read
      {2'd0, 8'hA0, 3'd2, 1'b1, 1'b0},   // R3 merged read
      {2'd1, 8'hB0, 3'd3, 1'b1, 1'b1},   // R2 write opens slot
      {2'd2, 8'hC0, 3'd4, 1'b1, 1'b1},   // R5 atomic
      {2'd2, 8'hC0, 3'd5, 1'b1, 1'b1},   // R5 second atomic
      {2'd1, 8'hA0, 3'd3, 1'b0, 1'b0},   // R11 write to busy line
      {2'd0, 8'hD0, 3'd6, 1'b1, 1'b1},   // fills last slot
      {2'd0, 8'hE0, 3'd7, 1'b0, 1'b0},   // R8 full
      {2'd2, 8'hA0, 3'd4, 1'b0, 1'b0},   // R11 atomic to fetch line
      {2'd0, 8'hC0, 3'd6, 1'b0, 1'b0}    // R11 read to atomic line
   };

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic eq(input string tag, input string what, input int act, input int exp);
      chk(act == exp, tag, what, act, exp);
   endtask

   task automatic look(input logic [7:0] a, input string tag, input bit ehit,
                       input int eidx, input int est, input int ew, input int ecnt);
      lk_addr = {8'h00, a};
      #1;
      eq(tag, "lk_hit", int'(lk_hit), int'(ehit));
      if (ehit) begin
         eq(tag, "lk_idx", int'(lk_idx), eidx);
         eq(tag, "lk_state", int'(lk_state), est);
         eq(tag, "lk_waiters", int'(lk_waiters), ew);
         eq(tag, "lk_count", int'(lk_count), ecnt);
      end
   endtask

   task automatic send_req(input logic [1:0] k, input logic [7:0] a, input logic [2:0] s,
                           input string tag, input bit erdy, input bit efwd);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = {8'h00, a}; req_src = s;
      #2;
      eq(tag, "req_ready", int'(req_ready), int'(erdy));
      eq(tag, "fwd_valid", int'(fwd_valid), int'(efwd));
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic send_rsp(input logic [1:0] k, input logic [7:0] a);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_kind = k; rsp_addr = {8'h00, a};
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 5000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      look(8'hA0, "R12", 1'b0, 0, 0, 0, 0);
      eq("R12", "full", int'(full), 0);
      eq("R12", "done_valid", int'(done_valid), 0);
      eq("R12", "underflow_err", int'(underflow_err), 0);
      req_kind = 2'd0; req_addr = 16'h00A0; #1;
      eq("R12", "req_ready", int'(req_ready), 1);

      foreach (VEC[i]) begin
         send_req(VEC[i][14:13], VEC[i][12:5], VEC[i][4:2],
                  $sformatf("vec%0d", i), VEC[i][1], VEC[i][0]);
      end

      @(negedge clk);
      eq("R8", "full", int'(full), 1);
      look(8'hE0, "R8", 1'b0, 0, 0, 0, 0);
      look(8'hA0, "R9", 1'b1, 0, 1, 8'h07, 0);
      look(8'hB0, "R2", 1'b1, 1, 3, 8'h00, 0);
      eq("R2", "lk_dirty", int'(lk_dirty), 1);
      look(8'hC0, "R5", 1'b1, 2, 2, 8'h30, 2);
      look(8'hD0, "R9", 1'b1, 3, 1, 8'h40, 0);

      // R4 fill fan-out
      send_rsp(2'd0, 8'hA0);
      #2;
      eq("R4", "rsp_dest", int'(rsp_dest), 8'h07);
      eq("R4", "unblock", int'(unblock), 1);
      @(posedge clk); #1 rsp_valid = 1'b0;
      @(negedge clk);
      look(8'hA0, "R4", 1'b0, 0, 0, 0, 0);
      eq("R4", "full", int'(full), 0);

      // R1 / R7 reuse of freed slot
      send_req(2'd0, 8'hE0, 3'd7, "R1", 1'b1, 1'b1);
      @(negedge clk);
      look(8'hE0, "R1", 1'b1, 0, 1, 8'h80, 0);

      // R5 / R6 atomic drain
      send_rsp(2'd1, 8'hC0);
      @(posedge clk); #1 rsp_valid = 1'b0;
      @(negedge clk);
      eq("R6", "done_valid early", int'(done_valid), 0);
      look(8'hC0, "R5", 1'b1, 2, 2, 8'h30, 1);
      send_rsp(2'd1, 8'hC0);
      @(posedge clk); #1 rsp_valid = 1'b0;
      @(negedge clk);
      eq("R6", "done_valid", int'(done_valid), 1);
      eq("R6", "done_idx", int'(done_idx), 2);
      @(posedge clk);
      @(negedge clk);
      look(8'hC0, "R6", 1'b0, 0, 0, 0, 0);
      eq("R6", "done_valid after", int'(done_valid), 0);

      // R10 underflow
      send_rsp(2'd1, 8'hE0);
      #2;
      eq("R10", "underflow_err", int'(underflow_err), 1);
      @(posedge clk); #1 rsp_valid = 1'b0;
      @(negedge clk);
      look(8'hE0, "R10", 1'b1, 0, 1, 8'h80, 0);
      eq("R10", "done_valid", int'(done_valid), 0);

      // R6 trigger discarded by a joining atomic
      send_req(2'd2, 8'hF0, 3'd1, "R6", 1'b1, 1'b1);
      send_rsp(2'd1, 8'hF0);
      @(posedge clk); #1 rsp_valid = 1'b0;
      @(negedge clk);
      eq("R6", "done_valid discard", int'(done_valid), 1);
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h00F0; req_src = 3'd2;
      #2;
      eq("R6", "join ready", int'(req_ready), 1);
      eq("R6", "join fwd", int'(fwd_valid), 1);
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      look(8'hF0, "R6", 1'b1, 2, 2, 8'h06, 1);

      // R7 write acknowledge frees write slot
      send_rsp(2'd2, 8'hB0);
      @(posedge clk); #1 rsp_valid = 1'b0;
      @(negedge clk);
      look(8'hB0, "R7", 1'b0, 0, 0, 0, 0);

      finish_run();
   end
endmodule